// File: doc/BRIEF.md
# Bunch-Crossing Tagged Hit Frame Sender

This block turns eight hit flags, already aligned to the bunch-crossing clock, into one 10-bit trigger frame on every machine cycle. Each frame pairs the eight hit bits with the two lowest bits of a free-running bunch-crossing counter. The counter value used is the one from the cycle in which the hits were captured. The frame then passes through a delay line whose depth can be programmed. Several senders that share one serial link can then be set to present frames from the same crossing at the same time.

The delay setting is loaded only on a bunch-crossing reset pulse. A run therefore never changes latency partway through, so no frame is repeated or lost. A frame-enable input forces the output to zero and drops the valid strobe. A test-pattern input replaces the hits with a walking one, for link checks.

Top module: `bx_frame_sender`

## Requirements
- R1: While `frame_en_i` is high at a rising edge, `frame_vld_o` is high after that edge. This gives one frame per clock with no gaps.
- R2: The frame layout is `frame_o[9:8]` = bunch-crossing tag and `frame_o[7:0]` = hit bits, with hit channel i on bit i.
- R3: The 12-bit bunch-crossing counter becomes 0 at an edge where `bx_rst_i` is high. Otherwise it increments by one every edge, wrapping modulo 4096.
- R4: The tag in a frame is counter bits [1:0] as they stood at the edge where that frame's hits were sampled. It is not the counter value at output time.
- R5: With an active delay D (0 to 15), the frame built from inputs sampled at edge t appears on `frame_o` after edge t+1+D.
- R6: `dly_cfg_i` becomes the active delay only at an edge where `bx_rst_i` is high. A change at any other time has no effect on output timing.
- R7: While `frame_en_i` is low at an edge, `frame_o` is all zeros and `frame_vld_o` is low after that edge. Frames in flight keep moving.
- R8: While `test_mode_i` is high at the sampling edge, the hit field is replaced by a one-hot value with bit (counter[2:0]) set.
- R9: While `rst_n` is low, `frame_o` is 0 and `frame_vld_o` is 0. The counter, the active delay and every stored frame clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bx_rst_i | input | 1 | Bunch-crossing reset pulse; clears counter, loads delay |
| hits_i | input | 8 | Synchronized hit flags, one per channel |
| dly_cfg_i | input | 4 | Requested alignment delay in cycles |
| frame_en_i | input | 1 | Frame enable; low forces a zero frame |
| test_mode_i | input | 1 | Replace hits with a walking-one pattern |
| frame_o | output | 10 | Output frame {tag[1:0], hits[7:0]} |
| frame_vld_o | output | 1 | Frame valid strobe |

## Verification
The bench targets the following corner cases, with the failure each one catches:
- **Tag sampled late.** A design that takes the tag at output time instead of capture time shows wrong frame bits [9:8] as soon as the delay is nonzero.
- **Delay applied early.** A design that lets a new delay value act without a bunch-crossing reset shifts the hit sequence in mid-run, so frames repeat or vanish.
- **Off-by-one delay.** A delay line off by one tap is exposed at delays 0, 5 and 15.
- **Tag restart.** A counter that fails to restart on the pulse shows a wrong tag directly after it.
- **Disabled cycles.** When the enable is low, the bench checks that the output is all zeros and that the pipeline keeps advancing.
- **Test pattern.** Test mode is checked against the walking-one position computed from the counter.

// File: rtl/bxf_pkg.sv
package bxf_pkg;
  localparam int HIT_W  = 8;
  localparam int TAG_W  = 2;
  localparam int WALK_W = $clog2(HIT_W);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [HIT_W-1:0] hits;
  } frame_t;
endpackage

// File: rtl/bxf_bx_counter.sv
module bxf_bx_counter #(
  parameter int BX_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bx_rst_i,
  output logic [bxf_pkg::TAG_W-1:0]   tag_o,
  output logic [bxf_pkg::WALK_W-1:0]  phase_o
);
  logic [BX_W-1:0] bx_q, bx_d;

  always_comb begin
    if (bx_rst_i) bx_d = '0;
    else          bx_d = bx_q + BX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bx_q <= '0;
    else        bx_q <= bx_d;
  end

  assign tag_o   = bx_q[bxf_pkg::TAG_W-1:0];
  assign phase_o = bx_q[bxf_pkg::WALK_W-1:0];

  p_bx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bx_rst_i |=> bx_q == '0);
  p_bx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_rst_i |=> bx_q == $past(bx_q) + BX_W'(1));
endmodule

// File: rtl/bxf_hit_capture.sv
module bxf_hit_capture (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [bxf_pkg::HIT_W-1:0]   hits_i,
  input  logic                        test_mode_i,
  input  logic [bxf_pkg::TAG_W-1:0]   tag_i,
  input  logic [bxf_pkg::WALK_W-1:0]  phase_i,
  output bxf_pkg::frame_t             cap_o
);
  import bxf_pkg::*;

  logic [HIT_W-1:0] walk;
  frame_t           cap_d, cap_q;

  always_comb begin
    walk       = HIT_W'(1) << phase_i;
    cap_d.tag  = tag_i;
    cap_d.hits = test_mode_i ? walk : hits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap_o = cap_q;

  p_walk_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_i |=> $onehot(cap_q.hits));
  p_hits_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode_i |=> cap_q.hits == $past(hits_i));
endmodule

// File: rtl/bxf_align_delay.sv
module bxf_align_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bx_rst_i,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  bxf_pkg::frame_t  din_i,
  output bxf_pkg::frame_t  dout_o
);
  import bxf_pkg::*;

  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [DLY_W-1:0] dly_q, dly_d;
  frame_t           taps [0:DEPTH];

  always_comb begin
    if (bx_rst_i) dly_d = dly_cfg_i;
    else          dly_d = dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign taps[0] = din_i;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    frame_t stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= taps[i-1];
    end
    assign taps[i] = stg_q;
  end

  assign dout_o = taps[dly_q];

  p_dly_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_rst_i |=> $stable(dly_q));
  p_dly_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bx_rst_i |=> dly_q == $past(dly_cfg_i));
endmodule

// File: rtl/bx_frame_sender.sv
module bx_frame_sender #(
  parameter int BX_W  = 12,
  parameter int DLY_W = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     bx_rst_i,
  input  logic [bxf_pkg::HIT_W-1:0]                hits_i,
  input  logic [DLY_W-1:0]                         dly_cfg_i,
  input  logic                                     frame_en_i,
  input  logic                                     test_mode_i,
  output logic [bxf_pkg::TAG_W+bxf_pkg::HIT_W-1:0] frame_o,
  output logic                                     frame_vld_o
);
  import bxf_pkg::*;

  localparam int FRM_W = TAG_W + HIT_W;

  logic [TAG_W-1:0]  tag;
  logic [WALK_W-1:0] phase;
  frame_t            cap, aligned;
  logic [FRM_W-1:0]  frm_d, frm_q;
  logic              vld_d, vld_q;

  bxf_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk(clk), .rst_n(rst_n), .bx_rst_i(bx_rst_i),
    .tag_o(tag), .phase_o(phase)
  );

  bxf_hit_capture u_cap (
    .clk(clk), .rst_n(rst_n), .hits_i(hits_i), .test_mode_i(test_mode_i),
    .tag_i(tag), .phase_i(phase), .cap_o(cap)
  );

  bxf_align_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .bx_rst_i(bx_rst_i),
    .dly_cfg_i(dly_cfg_i), .din_i(cap), .dout_o(aligned)
  );

  always_comb begin
    vld_d = frame_en_i;
    frm_d = frame_en_i ? aligned : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
      vld_q <= 1'b0;
    end else begin
      frm_q <= frm_d;
      vld_q <= vld_d;
    end
  end

  assign frame_o     = frm_q;
  assign frame_vld_o = vld_q;

  p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en_i |=> (frame_o == '0) && !frame_vld_o);
  p_every_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en_i |=> frame_vld_o);
  a_reset_r9: assert final (rst_n || (frame_o == '0 && !frame_vld_o));
endmodule

// File: tb/bx_frame_sender_test.sv
module bx_frame_sender_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bx_rst;
  logic [7:0] hits;
  logic [3:0] dly_cfg;
  logic       en;
  logic       tmode;
  logic [9:0] frame;
  logic       vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [9:0] hist[$];
  int         bx_m;
  int         dly_m;

  always #4 clk = ~clk;

  bx_frame_sender uut (
    .clk(clk), .rst_n(rst_n), .bx_rst_i(bx_rst), .hits_i(hits),
    .dly_cfg_i(dly_cfg), .frame_en_i(en), .test_mode_i(tmode),
    .frame_o(frame), .frame_vld_o(vld)
  );

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < 16; i++) hist.push_back(10'h0);
    bx_m = 0;
    dly_m = 0;
  endtask

  task automatic check(string req, logic [9:0] act_f, logic [9:0] exp_f,
                       logic act_v, logic exp_v);
    checks++;
    if (act_f !== exp_f || act_v !== exp_v) begin
      failures++;
      $display("FAIL %s: frame=%h vld=%b expected frame=%h vld=%b",
               req, act_f, act_v, exp_f, exp_v);
    end
  endtask

  task automatic cyc(string req, logic [7:0] h, logic e, logic [3:0] c,
                     logic t, logic b);
    logic [9:0] exp_f;
    logic [7:0] hsrc;
    hits = h; en = e; dly_cfg = c; tmode = t; bx_rst = b;
    @(posedge clk);
    exp_f = e ? hist[dly_m] : 10'h0;
    hsrc  = t ? 8'(1 << (bx_m % 8)) : h;
    hist.push_front({2'(bx_m % 4), hsrc});
    void'(hist.pop_back());
    bx_m  = b ? 0 : (bx_m + 1) % 4096;
    if (b) dly_m = int'(c);
    #2;
    check(req, frame, exp_f, vld, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bx_rst = 1'b0; hits = '0; dly_cfg = '0; en = 1'b1; tmode = 1'b0;
    model_reset();
    for (int i = 0; i < 3; i++) begin
      hits = 8'hA5;
      @(posedge clk); #2;
      check("R9 reset", frame, 10'h0, vld, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1 R2 R4: zero delay, varied hits
    for (int i = 0; i < 20; i++) cyc("R1 R2 R4 base", 8'($urandom), 1'b1, 4'd0, 1'b0, 1'b0);
    // R3 R5: restart counter with delay 5
    cyc("R3 bxrst", 8'h3C, 1'b1, 4'd5, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) cyc("R3 R4 R5 dly5", 8'(i * 37), 1'b1, 4'd5, 1'b0, 1'b0);
    // R6: new config without pulse is ignored
    for (int i = 0; i < 20; i++) cyc("R6 ignored", 8'($urandom), 1'b1, 4'd9, 1'b0, 1'b0);
    // R5: maximum delay
    cyc("R5 load15", 8'hFF, 1'b1, 4'd15, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) cyc("R5 R4 dly15", 8'($urandom), 1'b1, 4'd2, 1'b0, 1'b0);
    // R7: enable toggling
    for (int i = 0; i < 24; i++) cyc("R7 enable", 8'($urandom), 1'(i % 3 != 0), 4'd2, 1'b0, 1'b0);
    // R8: walking one
    for (int i = 0; i < 24; i++) cyc("R8 walk", 8'($urandom), 1'b1, 4'd2, 1'b1, 1'b0);
    // R3 R8: pulse during test mode, then delay 0
    cyc("R3 R8 bxrst", 8'h00, 1'b1, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) cyc("R3 R8 dly0", 8'h00, 1'b1, 4'd0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) cyc("R1 R2 tail", 8'($urandom), 1'b1, 4'd0, 1'b0, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule